// File: doc/BRIEF.md
# E1 CAS Timeslot-16 Signaling Inserter

This block produces the byte carried in timeslot 16 of every E1 basic frame when channel-associated signaling is in use. It keeps its own position within the 16-frame signaling multiframe and builds one byte per frame:

- In the first frame of the multiframe it sends the multiframe alignment word with the remote-alarm (Y) bit.
- In each of the other fifteen frames it sends the four-bit ABCD signaling codes of two payload channels.

The framer supplies a frame-sync strobe and its timeslot counter. The block returns the timeslot-16 byte, a strobe marking the timeslot-16 slot, and the current multiframe frame number.

Signaling codes come from one of two 30-channel banks, picked by a select input. One bank is a register bank. The other is a capture register fed by a serial stream. Three controls act on the codes:

- A per-channel clear-channel mask stops signaling from being inserted for a channel.
- The block never sends a code of 0000, so the alignment word cannot be mimicked.
- A global alarm override fills the timeslot with all ones.

Top module: `cas_ts16_inserter`

## Requirements
- R1: `mf_frame` advances by one at each clock edge that sees `frame_sync` high, and wraps from 15 to 0.
- R2: `mf_resync` high at an edge sets `mf_frame` to 0, and it wins over a `frame_sync` at the same edge.
- R3: In frame 0, `ts16_byte` is `0000` in bits 7..4, then 1 in bit 3, Y in bit 2, and 1 in bits 1 and 0. Y is 0 when `rx_mf_locked` is 1 and 1 when it is 0.
- R4: In frame n (1..15), bits 7..4 carry channel n and bits 3..0 carry channel n+15. Channel k (1..30) sits at bits `4k-1 : 4k-4` of the selected bank.
- R5: `src_sel` = 0 takes the codes from `reg_sig`, and `src_sel` = 1 takes them from `ser_sig`.
- R6: For a channel whose `clear_chan` bit (bit k-1 for channel k) is 1, the idle code 1101 is sent in place of its code.
- R7: A selected code of 0000 is sent as the idle code 1101, so no signaling nibble is ever 0000.
- R8: While `ais_ts16` is 1, `ts16_byte` is 8'hFF in every frame.
- R9: `ts16_valid` is 1 in the cycle after an edge at which `ts_index` equals 16, and 0 otherwise.
- R10: `ts16_byte` is registered. It shows the inputs and `mf_frame` as they were at the previous clock edge. After reset it is 8'hFF, with `mf_frame` = 0 and `ts16_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe at each basic-frame start |
| mf_resync | input | 1 | Forces the multiframe count to 0 |
| ts_index | input | 5 | Framer timeslot counter for the current frame |
| rx_mf_locked | input | 1 | Receive signaling multiframe alignment acquired |
| src_sel | input | 1 | Signaling source: 0 register bank, 1 serial capture |
| ais_ts16 | input | 1 | All-ones override of timeslot 16 |
| clear_chan | input | 30 | Per-channel signaling block, bit k-1 for channel k |
| reg_sig | input | 120 | Register-bank ABCD codes, 4 bits per channel |
| ser_sig | input | 120 | Serial-capture ABCD codes, 4 bits per channel |
| ts16_byte | output | 8 | Timeslot-16 byte for the current frame |
| ts16_valid | output | 1 | Marks the timeslot-16 slot, one cycle after `ts_index` = 16 |
| mf_frame | output | 4 | Current basic frame number within the multiframe |

## Verification
`mf_frame` changes at the same edge that samples `frame_sync` or `mf_resync`, so it is checked at the following falling edge. `ts16_byte` lies one register further on. A change to a control or a code is checked one edge after it is applied. A frame-sync is checked two edges later: the wrap test checks explicitly that the byte still shows frame 15 while `mf_frame` already reads 0. `ts16_valid` is checked one edge after `ts_index` reaches 16 and again one edge after it leaves. All inputs are driven and all outputs sampled on falling edges.

// File: rtl/cas_pkg.sv
// Shared constants for the timeslot-16 signaling inserter.
// Assumes the standard E1 layout: 4-bit ABCD codes, 16-frame multiframe.
package cas_pkg;
    localparam int          NIB_W    = 4;
    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  ALIGN_NIB = 4'b0000;  // multiframe alignment word
    localparam logic [3:0]  IDLE_NIB  = 4'b1101;  // substitute for blocked/zero codes
    localparam logic [7:0]  ALL_ONES  = 8'hFF;    // alarm fill pattern
endpackage

// File: rtl/cas_mf_counter.sv
// Multiframe position counter.
// Advances once per frame_sync, wraps at MF_LEN-1, resync wins and forces 0.
// Assumes frame_sync is a single-cycle strobe.
module cas_mf_counter #(
    parameter int MF_LEN = 16,
    localparam int MF_W  = $clog2(MF_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    input  logic            mf_resync,
    output logic [MF_W-1:0] mf_q
);
    localparam logic [MF_W-1:0] LAST = MF_W'(MF_LEN - 1);

    // Track the basic-frame number inside the multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mf_q <= '0;
        end else if (mf_resync) begin
            mf_q <= '0;
        end else if (frame_sync) begin
            mf_q <= (mf_q == LAST) ? '0 : mf_q + 1'b1;
        end
    end

    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !mf_resync && mf_q != LAST) |=> (mf_q == $past(mf_q) + 1'b1));
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !mf_resync && mf_q == LAST) |=> (mf_q == '0));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && !mf_resync) |=> $stable(mf_q));
    p_resync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mf_resync |=> (mf_q == '0));
endmodule

// File: rtl/cas_nibble_sel.sv
// Per-channel signaling code selection.
// Picks register or serial bank, then replaces blocked or all-zero codes
// with the idle code so the alignment word can never be mimicked.
// Purely combinational; clk/rst_n serve only the embedded checks.
module cas_nibble_sel
    import cas_pkg::*;
#(
    parameter int N_CH = 30
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        src_sel,
    input  logic [N_CH-1:0]             clear_chan,
    input  logic [N_CH*NIB_W-1:0]       reg_sig,
    input  logic [N_CH*NIB_W-1:0]       ser_sig,
    output logic [N_CH-1:0][NIB_W-1:0]  nib_out
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [NIB_W-1:0] raw;

        // Source select, then clear-channel / zero-code substitution.
        always_comb begin
            raw = src_sel ? ser_sig[c*NIB_W +: NIB_W] : reg_sig[c*NIB_W +: NIB_W];
            if (clear_chan[c] || raw == ALIGN_NIB) begin
                nib_out[c] = IDLE_NIB;
            end else begin
                nib_out[c] = raw;
            end
        end

        p_no_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            nib_out[c] != ALIGN_NIB);
        p_clear_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clear_chan[c] |-> (nib_out[c] == IDLE_NIB));
    end
endmodule

// File: rtl/cas_ts16_builder.sv
// Builds and registers the timeslot-16 byte for the current frame.
// Frame 0: alignment word plus spare/Y bits; frame n: channel n and n+15 codes.
// Assumes N_CH == 2*(MF_LEN-1).
module cas_ts16_builder
    import cas_pkg::*;
#(
    parameter int N_CH   = 30,
    parameter int MF_LEN = 16,
    localparam int MF_W  = $clog2(MF_LEN),
    localparam int PAIRS = N_CH / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MF_W-1:0]             mf_q,
    input  logic                        rx_mf_locked,
    input  logic                        ais_ts16,
    input  logic [N_CH-1:0][NIB_W-1:0]  nib,
    output logic [BYTE_W-1:0]           byte_q
);
    logic [BYTE_W-1:0] byte_d;

    // Compose the byte for the current multiframe position.
    always_comb begin
        byte_d = {ALIGN_NIB, 1'b1, ~rx_mf_locked, 2'b11};
        for (int f = 1; f < MF_LEN; f++) begin
            if (mf_q == MF_W'(f)) begin
                byte_d = {nib[f-1], nib[f-1+PAIRS]};
            end
        end
        if (ais_ts16) begin
            byte_d = ALL_ONES;
        end
    end

    // Register the byte toward the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= ALL_ONES;
        end else begin
            byte_q <= byte_d;
        end
    end

    p_ais_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ais_ts16 |=> (byte_q == ALL_ONES));
    p_align_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ais_ts16 && mf_q == '0) |=> (byte_q[7:4] == ALIGN_NIB && byte_q[2] == !$past(rx_mf_locked)));
    p_no_mimic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ais_ts16 && mf_q != '0) |=> (byte_q[7:4] != ALIGN_NIB && byte_q[3:0] != ALIGN_NIB));
endmodule

// File: rtl/cas_ts16_inserter.sv
// Top of the E1 CAS timeslot-16 transmit inserter.
// Ties together multiframe counter, code selection and byte builder, and
// flags the timeslot-16 slot from the framer's timeslot counter.
module cas_ts16_inserter
    import cas_pkg::*;
#(
    parameter int N_CH   = 30,
    parameter int MF_LEN = 16,
    parameter int TS_W   = 5,
    parameter int SIG_TS = 16,
    localparam int MF_W  = $clog2(MF_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_sync,
    input  logic                  mf_resync,
    input  logic [TS_W-1:0]       ts_index,
    input  logic                  rx_mf_locked,
    input  logic                  src_sel,
    input  logic                  ais_ts16,
    input  logic [N_CH-1:0]       clear_chan,
    input  logic [N_CH*NIB_W-1:0] reg_sig,
    input  logic [N_CH*NIB_W-1:0] ser_sig,
    output logic [BYTE_W-1:0]     ts16_byte,
    output logic                  ts16_valid,
    output logic [MF_W-1:0]       mf_frame
);
    logic [N_CH-1:0][NIB_W-1:0] nib;

    cas_mf_counter #(.MF_LEN(MF_LEN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .mf_resync(mf_resync), .mf_q(mf_frame)
    );

    cas_nibble_sel #(.N_CH(N_CH)) u_sel (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .clear_chan(clear_chan),
        .reg_sig(reg_sig), .ser_sig(ser_sig), .nib_out(nib)
    );

    cas_ts16_builder #(.N_CH(N_CH), .MF_LEN(MF_LEN)) u_bld (
        .clk(clk), .rst_n(rst_n), .mf_q(mf_frame), .rx_mf_locked(rx_mf_locked),
        .ais_ts16(ais_ts16), .nib(nib), .byte_q(ts16_byte)
    );

    // Mark the timeslot-16 slot one cycle after the framer reaches it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts16_valid <= 1'b0;
        end else begin
            ts16_valid <= (ts_index == TS_W'(SIG_TS));
        end
    end

    p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_index == TS_W'(SIG_TS)) |=> ts16_valid);
    p_valid_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_index != TS_W'(SIG_TS)) |=> !ts16_valid);
endmodule

// File: tb/cas_ts16_inserter_tb.sv
// Self-checking bench: table of frame/control vectors, then directed tests.
module cas_ts16_inserter_tb;
    localparam int N_CH = 30;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_sync = 1'b0, mf_resync = 1'b0;
    logic [4:0]   ts_index = '0;
    logic         rx_mf_locked = 1'b1, src_sel = 1'b0, ais_ts16 = 1'b0;
    logic [29:0]  clear_chan = '0;
    logic [119:0] reg_sig, ser_sig;
    logic [7:0]   ts16_byte;
    logic         ts16_valid;
    logic [3:0]   mf_frame;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cas_ts16_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mf_resync(mf_resync),
        .ts_index(ts_index), .rx_mf_locked(rx_mf_locked), .src_sel(src_sel),
        .ais_ts16(ais_ts16), .clear_chan(clear_chan), .reg_sig(reg_sig),
        .ser_sig(ser_sig), .ts16_byte(ts16_byte), .ts16_valid(ts16_valid),
        .mf_frame(mf_frame)
    );

    // Fields: frame(4) src(1) locked(1) ais(1) clear_ch(5, 0 = none) expected(8)
    // Register bank code for channel k is k[3:0]; serial bank is ~k[3:0].
    localparam logic [19:0] VEC [0:12] = '{
        {4'd0,  1'b0, 1'b1, 1'b0, 5'd0,  8'h0B},  // R3 locked: Y=0
        {4'd0,  1'b0, 1'b0, 1'b0, 5'd0,  8'h0F},  // R3 unlocked: Y=1
        {4'd1,  1'b0, 1'b1, 1'b0, 5'd0,  8'h1D},  // R4 R7 ch16 code 0 -> idle
        {4'd5,  1'b0, 1'b1, 1'b0, 5'd0,  8'h54},  // R4
        {4'd15, 1'b0, 1'b1, 1'b0, 5'd0,  8'hFE},  // R4 last frame
        {4'd15, 1'b1, 1'b1, 1'b0, 5'd0,  8'hD1},  // R5 R7 serial ch15 zero
        {4'd5,  1'b1, 1'b1, 1'b0, 5'd0,  8'hAB},  // R5
        {4'd5,  1'b0, 1'b1, 1'b0, 5'd20, 8'h5D},  // R6 lower channel blocked
        {4'd5,  1'b0, 1'b1, 1'b0, 5'd5,  8'hD4},  // R6 upper channel blocked
        {4'd7,  1'b0, 1'b1, 1'b1, 5'd0,  8'hFF},  // R8
        {4'd0,  1'b0, 1'b1, 1'b1, 5'd0,  8'hFF},  // R8 over alignment frame
        {4'd10, 1'b1, 1'b1, 1'b0, 5'd0,  8'h56},  // R5 R4
        {4'd1,  1'b1, 1'b1, 1'b0, 5'd0,  8'hEF}   // R5 R4
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Resync, then step the multiframe to frame m; ends on a falling edge.
    task automatic goto_mf(input int m);
        @(negedge clk) mf_resync = 1'b1;
        @(negedge clk) mf_resync = 1'b0;
        for (int i = 0; i < m; i++) begin
            frame_sync = 1'b1;
            @(negedge clk) frame_sync = 1'b0;
        end
    endtask

    initial begin
        for (int k = 1; k <= N_CH; k++) begin
            reg_sig[4*(k-1) +: 4] = 4'(k);
            ser_sig[4*(k-1) +: 4] = ~4'(k);
        end
        repeat (3) @(negedge clk);
        check("R10 reset byte", ts16_byte, 8'hFF);
        check("R10 reset frame", {4'h0, mf_frame}, 8'h00);
        check("R10 reset valid", {7'h0, ts16_valid}, 8'h00);
        rst_n = 1'b1;

        // Vector table.
        for (int v = 0; v < 13; v++) begin
            goto_mf(int'(VEC[v][19:16]));
            src_sel      = VEC[v][15];
            rx_mf_locked = VEC[v][14];
            ais_ts16     = VEC[v][13];
            clear_chan   = (VEC[v][12:8] == 0) ? '0 : 30'(1) << (VEC[v][12:8] - 1);
            @(negedge clk);
            check($sformatf("R3/R4/R5/R6/R7/R8 vec%0d", v), ts16_byte, VEC[v][7:0]);
            src_sel = 1'b0; rx_mf_locked = 1'b1; ais_ts16 = 1'b0; clear_chan = '0;
        end

        // R1: advance and wrap; R10: byte trails mf_frame by one edge.
        goto_mf(3);
        check("R1 advance", {4'h0, mf_frame}, 8'h03);
        goto_mf(15);
        check("R1 reach 15", {4'h0, mf_frame}, 8'h0F);
        frame_sync = 1'b1;
        @(negedge clk) frame_sync = 1'b0;
        check("R1 wrap", {4'h0, mf_frame}, 8'h00);
        check("R10 byte lags", ts16_byte, 8'hFE);
        @(negedge clk);
        check("R10 byte after lag", ts16_byte, 8'h0B);

        // R2: resync wins over a simultaneous frame_sync.
        goto_mf(6);
        mf_resync = 1'b1; frame_sync = 1'b1;
        @(negedge clk) begin mf_resync = 1'b0; frame_sync = 1'b0; end
        check("R2 resync priority", {4'h0, mf_frame}, 8'h00);

        // R9: valid strobe timing.
        ts_index = 5'd15;
        @(negedge clk);
        check("R9 not slot", {7'h0, ts16_valid}, 8'h00);
        ts_index = 5'd16;
        @(negedge clk);
        check("R9 slot", {7'h0, ts16_valid}, 8'h01);
        ts_index = 5'd17;
        @(negedge clk);
        check("R9 after slot", {7'h0, ts16_valid}, 8'h00);

        // R8 release: leaving AIS restores the frame content one edge later.
        goto_mf(5);
        ais_ts16 = 1'b1;
        @(negedge clk);
        check("R8 on", ts16_byte, 8'hFF);
        ais_ts16 = 1'b0;
        @(negedge clk);
        check("R8 release", ts16_byte, 8'h54);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule